// File: doc/BRIEF.md
# Bidirectional Register-Controlled I/O Port

This block is a seven-pin general-purpose I/O port. Software reaches it through two byte-wide registers on a small synchronous register bus. One register sets the direction of each pin. The other holds the output levels. For pins that are inputs, that same latch switches on a pull-up. The port samples every raw pin level through a two-flop synchronizer. It sends those synchronized levels unchanged to neighbouring timer-capture and interrupt logic, and it also uses them for register read-back.

The direction register can be written but not read back. A read of the data register builds its answer bit by bit. An output pin returns its latch value. An input pin returns its live, synchronized level and skips the latch, even when capture or interrupt logic is using that pin. A timer can take over pins 1 and 2 through dedicated override inputs. While it does, the timer value replaces the latch on that pin and the pin is driven whatever its direction bit says.

Top module: `bidir_io_port`

## Requirements
- R1: After reset, every pin is an input with its pull-up off and output value 0 (`pin_oe_o`, `pin_pu_o` and `pin_o` all 0), and a data-register read with all pins low returns 0x80.
- R2: Only address 0xFFB9 (direction) and 0xFFBB (data) are decoded. A write to any other address changes no output, and a read of any other address returns 0x00.
- R3: Without timer override, a direction bit of 1 drives `pin_oe_o` for that pin high and a 0 drives it low. `pin_o` always carries the data latch bit for that pin.
- R4: A read of the direction register returns 0xFF whatever it holds.
- R5: A data-register read returns, for bit n (n = 0..6), the latch bit when direction bit n is 1 and the synchronized pin level when it is 0. Bit 7 always reads 1.
- R6: `pin_pu_o` for a pin is 1 exactly when the pin is not driven and its latch bit is 1. A driven pin never has its pull-up on.
- R7: Bit 7 of written data is ignored in both registers. Writing 0xF0 to direction enables only pins 4..6, and a written 0x00 to data still reads back bit 7 as 1.
- R8: `pin_lvl_o` equals `pin_i` delayed by exactly two clock edges, and read-back uses that same synchronized level.
- R9: When `tmr_oe_i[k]` is 1 (k = 0 for pin 1, k = 1 for pin 2), that pin has `pin_oe_o` = 1, `pin_o` = `tmr_val_i[k]` and pull-up off, whatever its direction and latch bits hold. Other pins are unaffected.
- R10: `rdata_o` carries the read result in the cycle after the edge that samples `rd_i`, and is 0x00 in any cycle that follows an edge without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | Register bus address |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, one cycle after the read strobe |
| pin_i | input | 7 | Raw pin levels |
| pin_o | output | 7 | Pin output values |
| pin_oe_o | output | 7 | Pin output enables |
| pin_pu_o | output | 7 | Pin pull-up enables |
| pin_lvl_o | output | 7 | Synchronized pin levels for capture and interrupt logic |
| tmr_oe_i | input | 2 | Timer override enable for pins 1 and 2 |
| tmr_val_i | input | 2 | Timer output values for pins 1 and 2 |

## Verification
The assertions assume that at most one of `wr_i` and `rd_i` is high in a cycle. They assume the timer override is idle while reset is asserted, and that pin levels change at most once per cycle relative to the clock. The bench changes every input on the falling edge and issues bus strobes one at a time, each lasting a single cycle. It leaves `tmr_oe_i` at zero except in the override test, which runs well after reset. Read-back checks wait at least three edges after a pin change so that the synchronizer has settled.

// File: rtl/bidir_io_pkg.sv
package bidir_io_pkg;
  localparam int unsigned REG_W = 8;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_DIR  = 2'd1,
    SEL_DATA = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/bidir_io_sync.sv
module bidir_io_sync #(
  parameter int unsigned WIDTH  = 7,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/bidir_io_regs.sv
module bidir_io_regs
  import bidir_io_pkg::*;
#(
  parameter int unsigned NUM_PINS  = 7,
  parameter int unsigned ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] DIR_ADDR  = 16'hFFB9,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 16'hFFBB
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                wr_i,
  input  logic [REG_W-1:0]    wdata_i,
  output reg_sel_e            sel_o,
  output logic [NUM_PINS-1:0] dir_o,
  output logic [NUM_PINS-1:0] latch_o
);
  logic unused_rsvd;
  assign unused_rsvd = ^wdata_i[REG_W-1:NUM_PINS];

  always_comb begin
    if (addr_i == DIR_ADDR)       sel_o = SEL_DIR;
    else if (addr_i == DATA_ADDR) sel_o = SEL_DATA;
    else                          sel_o = SEL_NONE;
  end

  // reserved bit 7 has no storage; reset value 0x80 is reproduced on read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_o   <= '0;
      latch_o <= '0;
    end else if (wr_i) begin
      if (sel_o == SEL_DIR)  dir_o   <= wdata_i[NUM_PINS-1:0];
      if (sel_o == SEL_DATA) latch_o <= wdata_i[NUM_PINS-1:0];
    end
  end
endmodule

// File: rtl/bidir_io_pins.sv
module bidir_io_pins #(
  parameter int unsigned NUM_PINS = 7,
  parameter int unsigned TMR_BASE = 1,
  parameter int unsigned TMR_PINS = 2
) (
  input  logic [NUM_PINS-1:0] dir_i,
  input  logic [NUM_PINS-1:0] latch_i,
  input  logic [TMR_PINS-1:0] tmr_oe_i,
  input  logic [TMR_PINS-1:0] tmr_val_i,
  output logic [NUM_PINS-1:0] pin_o,
  output logic [NUM_PINS-1:0] pin_oe_o,
  output logic [NUM_PINS-1:0] pin_pu_o
);
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic oe, val;
    if (i >= TMR_BASE && i < TMR_BASE + TMR_PINS) begin : g_tmr
      localparam int unsigned K = i - TMR_BASE;
      assign oe  = tmr_oe_i[K] | dir_i[i];
      assign val = tmr_oe_i[K] ? tmr_val_i[K] : latch_i[i];
    end else begin : g_plain
      assign oe  = dir_i[i];
      assign val = latch_i[i];
    end
    assign pin_o[i]    = val;
    assign pin_oe_o[i] = oe;
    // latch doubles as pull-up enable, only while undriven
    assign pin_pu_o[i] = ~oe & latch_i[i];
  end
endmodule

// File: rtl/bidir_io_rdmux.sv
module bidir_io_rdmux
  import bidir_io_pkg::*;
#(
  parameter int unsigned NUM_PINS = 7
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rd_i,
  input  reg_sel_e            sel_i,
  input  logic [NUM_PINS-1:0] dir_i,
  input  logic [NUM_PINS-1:0] latch_i,
  input  logic [NUM_PINS-1:0] lvl_i,
  output logic [REG_W-1:0]    rdata_o
);
  localparam int unsigned RSVD_W = REG_W - NUM_PINS;

  logic [REG_W-1:0] rd_val;

  always_comb begin
    unique case (sel_i)
      SEL_DIR:  rd_val = '1;
      SEL_DATA: rd_val = {{RSVD_W{1'b1}}, (dir_i & latch_i) | (~dir_i & lvl_i)};
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (rd_i) rdata_o <= rd_val;
    else           rdata_o <= '0;
  end
endmodule

// File: rtl/bidir_io_port.sv
module bidir_io_port
  import bidir_io_pkg::*;
#(
  parameter int unsigned NUM_PINS  = 7,
  parameter int unsigned ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] DIR_ADDR  = 16'hFFB9,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 16'hFFBB,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned TMR_BASE  = 1,
  parameter int unsigned TMR_PINS  = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                wr_i,
  input  logic                rd_i,
  input  logic [REG_W-1:0]    wdata_i,
  output logic [REG_W-1:0]    rdata_o,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] pin_o,
  output logic [NUM_PINS-1:0] pin_oe_o,
  output logic [NUM_PINS-1:0] pin_pu_o,
  output logic [NUM_PINS-1:0] pin_lvl_o,
  input  logic [TMR_PINS-1:0] tmr_oe_i,
  input  logic [TMR_PINS-1:0] tmr_val_i
);
  reg_sel_e            sel;
  logic [NUM_PINS-1:0] dir_q, latch_q, lvl;

  bidir_io_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(pin_i), .q_o(lvl)
  );

  bidir_io_regs #(
    .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .DIR_ADDR(DIR_ADDR), .DATA_ADDR(DATA_ADDR)
  ) u_regs (
    .clk_i, .rst_ni, .addr_i, .wr_i, .wdata_i,
    .sel_o(sel), .dir_o(dir_q), .latch_o(latch_q)
  );

  bidir_io_pins #(.NUM_PINS(NUM_PINS), .TMR_BASE(TMR_BASE), .TMR_PINS(TMR_PINS)) u_pins (
    .dir_i(dir_q), .latch_i(latch_q), .tmr_oe_i, .tmr_val_i,
    .pin_o, .pin_oe_o, .pin_pu_o
  );

  bidir_io_rdmux #(.NUM_PINS(NUM_PINS)) u_rdmux (
    .clk_i, .rst_ni, .rd_i, .sel_i(sel),
    .dir_i(dir_q), .latch_i(latch_q), .lvl_i(lvl), .rdata_o
  );

  assign pin_lvl_o = lvl;
endmodule

// File: rtl/bidir_io_port_chk.sv
module bidir_io_port_chk #(
  parameter int unsigned NUM_PINS  = 7,
  parameter int unsigned ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] DIR_ADDR  = 16'hFFB9,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 16'hFFBB,
  parameter int unsigned TMR_PINS  = 2
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [ADDR_W-1:0]   addr_i,
  input logic                wr_i,
  input logic                rd_i,
  input logic [7:0]          wdata_i,
  input logic [7:0]          rdata_o,
  input logic [NUM_PINS-1:0] pin_i,
  input logic [NUM_PINS-1:0] pin_o,
  input logic [NUM_PINS-1:0] pin_oe_o,
  input logic [NUM_PINS-1:0] pin_pu_o,
  input logic [NUM_PINS-1:0] pin_lvl_o,
  input logic [TMR_PINS-1:0] tmr_oe_i,
  input logic [TMR_PINS-1:0] tmr_val_i
);
  logic [1:0] since_rst;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  always_comb begin
    if (!rst_ni && tmr_oe_i == '0)
      assert_reset_idle_R1: assert (pin_oe_o == '0 && pin_pu_o == '0 && pin_o == '0);
  end

  assert_dir_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == DIR_ADDR) |=> pin_oe_o[0] == $past(wdata_i[0]));

  assert_dir_read_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == DIR_ADDR) |=> rdata_o == 8'hFF);

  assert_data_rsvd_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == DATA_ADDR) |=> rdata_o[7]);

  assert_pu_off_driven_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_pu_o & pin_oe_o) == '0);

  assert_sync_delay_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst >= 2'd2) |-> pin_lvl_o == $past(pin_i, 2));

  assert_tmr_take_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_oe_i[0] |-> (pin_oe_o[1] && !pin_pu_o[1] && pin_o[1] == tmr_val_i[0]));

  assert_idle_read_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> rdata_o == 8'h00);

  assert_unmapped_read_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i != DIR_ADDR && addr_i != DATA_ADDR) |=> rdata_o == 8'h00);
endmodule

bind bidir_io_port bidir_io_port_chk #(
  .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .DIR_ADDR(DIR_ADDR),
  .DATA_ADDR(DATA_ADDR), .TMR_PINS(TMR_PINS)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_i(wr_i), .rd_i(rd_i),
  .wdata_i(wdata_i), .rdata_o(rdata_o), .pin_i(pin_i), .pin_o(pin_o),
  .pin_oe_o(pin_oe_o), .pin_pu_o(pin_pu_o), .pin_lvl_o(pin_lvl_o),
  .tmr_oe_i(tmr_oe_i), .tmr_val_i(tmr_val_i)
);

// File: tb/bidir_io_port_tb.sv
module bidir_io_port_tb;
  localparam logic [15:0] A_DIR  = 16'hFFB9;
  localparam logic [15:0] A_DATA = 16'hFFBB;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] addr_i = '0;
  logic        wr_i = 1'b0, rd_i = 1'b0;
  logic [7:0]  wdata_i = '0;
  logic [7:0]  rdata_o;
  logic [6:0]  pin_i = '0, pin_o, pin_oe_o, pin_pu_o, pin_lvl_o;
  logic [1:0]  tmr_oe_i = '0, tmr_val_i = '0;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  bidir_io_port u_dut (.*);

  typedef struct packed {
    logic [7:0] dir;
    logic [7:0] data;
    logic [6:0] pins;
    logic [6:0] e_oe;
    logic [6:0] e_out;
    logic [6:0] e_pu;
    logic [7:0] e_rd;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{8'h00, 8'h00, 7'h7F, 7'h00, 7'h00, 7'h00, 8'hFF},
    '{8'h7F, 8'h55, 7'h00, 7'h7F, 7'h55, 7'h00, 8'hD5},
    '{8'h0F, 8'h3C, 7'h50, 7'h0F, 7'h3C, 7'h30, 8'hDC},
    '{8'hF0, 8'h81, 7'h2A, 7'h70, 7'h01, 7'h01, 8'h8A},
    '{8'h33, 8'hFF, 7'h44, 7'h33, 7'h7F, 7'h4C, 8'hF7},
    '{8'h00, 8'h7F, 7'h00, 7'h00, 7'h7F, 7'h7F, 8'h80}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic bus_rd(input logic [15:0] a, output logic [7:0] d);
    addr_i = a; rd_i = 1'b1;
    @(negedge clk_i);
    rd_i = 1'b0;
    d = rdata_o;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk_i);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check("R1 oe", {1'b0, pin_oe_o}, 8'h00);
    check("R1 pu", {1'b0, pin_pu_o}, 8'h00);
    check("R1 out", {1'b0, pin_o}, 8'h00);
    rst_ni = 1'b1;
    @(negedge clk_i);
    bus_rd(A_DATA, rd); check("R1 data read", rd, 8'h80);
    bus_rd(A_DIR, rd);  check("R4 dir read", rd, 8'hFF);
    @(negedge clk_i);
    check("R10 idle rdata", rdata_o, 8'h00);

    // table walk: R3 R5 R6 R7
    for (int v = 0; v < NV; v++) begin
      bus_wr(A_DIR, VECS[v].dir);
      bus_wr(A_DATA, VECS[v].data);
      pin_i = VECS[v].pins;
      settle();
      check("R3 oe", {1'b0, pin_oe_o}, {1'b0, VECS[v].e_oe});
      check("R3 out", {1'b0, pin_o}, {1'b0, VECS[v].e_out});
      check("R6 pu", {1'b0, pin_pu_o}, {1'b0, VECS[v].e_pu});
      bus_rd(A_DATA, rd); check("R5 data read", rd, VECS[v].e_rd);
    end
    bus_rd(A_DIR, rd); check("R4 dir read after writes", rd, 8'hFF);

    // R7 bit 7 ignored on data write
    bus_wr(A_DATA, 8'h00);
    bus_rd(A_DATA, rd); check("R7 rsvd data bit", rd, 8'h80);

    // R2 unmapped writes and reads
    bus_wr(A_DIR, 8'h00);
    bus_wr(A_DATA, 8'h00);
    bus_wr(16'hFFBA, 8'h7F);
    bus_wr(16'hFFB8, 8'h7F);
    bus_wr(16'hFFBC, 8'h7F);
    bus_wr(16'h00B9, 8'h7F);
    check("R2 oe after unmapped", {1'b0, pin_oe_o}, 8'h00);
    check("R2 out after unmapped", {1'b0, pin_o}, 8'h00);
    bus_rd(16'hFFBA, rd); check("R2 unmapped read", rd, 8'h00);

    // R8 synchronizer latency
    pin_i = 7'h00; settle();
    pin_i = 7'h41;
    @(negedge clk_i);
    check("R8 lvl after 1 edge", {1'b0, pin_lvl_o}, 8'h00);
    @(negedge clk_i);
    check("R8 lvl after 2 edges", {1'b0, pin_lvl_o}, 8'h41);
    bus_rd(A_DATA, rd); check("R8 read uses sync level", rd, 8'hC1);

    // R9 timer override on pin 2 (k=1), pin 1 left alone
    pin_i = 7'h00;
    bus_wr(A_DATA, 8'h06);
    settle();
    check("R9 pu before override", {1'b0, pin_pu_o}, 8'h06);
    tmr_oe_i = 2'b10; tmr_val_i = 2'b01;
    @(negedge clk_i);
    check("R9 oe", {1'b0, pin_oe_o}, 8'h04);
    check("R9 out", {1'b0, pin_o}, 8'h02);
    check("R9 pu", {1'b0, pin_pu_o}, 8'h02);
    tmr_oe_i = 2'b01; tmr_val_i = 2'b10;
    @(negedge clk_i);
    check("R9 oe pin1", {1'b0, pin_oe_o}, 8'h02);
    check("R9 out pin1", {1'b0, pin_o}, 8'h04);
    tmr_oe_i = 2'b00;
    @(negedge clk_i);
    check("R9 release", {1'b0, pin_oe_o}, 8'h00);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule